// File: doc/BRIEF.md
# Long-Exposure Field Mask Controller

This block stretches an image sensor exposure across many frames. Once software has armed the primary field counter and written a start trigger, the block counts vertical-sync (VD) strobes. For a programmed number of fields it raises two separate mask enables. One suppresses the readout (sense-gate) pulses. The other suppresses the substrate charge-clear pulses. The pulse generators downstream AND their outputs with the inverse of these masks.

The two mask lengths are independent field counts of 13 bits by default. An optional skip-first setting leaves the field after the trigger unmasked, so the exposure starts one field later. When both lengths are zero the masks never rise, but the counter still runs and its busy flag still marks the fields. A secondary field counter with its own enable, trigger and length gives a one-cycle terminal pulse and has no effect on the masks.

Top module: `lexp_mask_ctrl`

## Requirements
- R1: While reset is held low (active-low, synchronous), and in the first cycle after it, both masks, the busy flag and the secondary terminal pulse are low.
- R2: A trigger starts an exposure only when the arm enable is high in the same cycle and busy is low. Busy is then high from the next cycle. The mask lengths and skip-first are latched at that trigger. A trigger seen while busy, or while the arm enable is low, has no effect.
- R3: The first active field is the one opened by the first VD strobe after the trigger. A mask that covers it goes high in the cycle after that strobe is sampled, and never earlier.
- R4: With the active field index j counting 1, 2, … from the first active field, the sense-gate mask is high exactly in fields 1 ≤ j ≤ sense-gate length. It goes low in the cycle after the VD that ends field j equal to the length.
- R5: The substrate mask follows the same rule with the substrate length, independently of the sense-gate mask.
- R6: With skip-first set, the field opened by the first VD after the trigger has j = 0 and is unmasked, so every masked field moves one field later.
- R7: With both lengths zero, a trigger leaves both masks low. Busy still rises and stays high for max(lengths)+skip fields, which is zero or one field.
- R8: Busy falls in the cycle after the VD that closes field j = max(sense-gate length, substrate length), and the masks are low from then on.
- R9: Lengths up to 8191 fields work, so a skipped field plus masking covers up to 8192 VD periods.
- R10: Dropping the arm enable aborts an exposure: busy and both masks are low in the next cycle.
- R11: The secondary counter starts on its trigger when its enable is high and it is idle. Its terminal output is a one-cycle pulse in the cycle after the N-th following VD, where N is its length (0 counts as 1). A secondary trigger while it is running is ignored, and dropping its enable stops it.
- R12: Activity of the secondary counter never changes the masks or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vd_i | input | 1 | One-cycle strobe at the start of each field |
| arm_en_i | input | 1 | Enables the primary field counter; low aborts an exposure |
| trig_i | input | 1 | One-cycle start pulse for a long exposure |
| skip_first_i | input | 1 | Leave the first field after the trigger unmasked |
| sg_len_i | input | CNT_W | Sense-gate mask length in fields |
| sub_len_i | input | CNT_W | Substrate-clear mask length in fields |
| aux_en_i | input | 1 | Enables the secondary counter |
| aux_trig_i | input | 1 | Start pulse for the secondary counter |
| aux_len_i | input | CNT_W | Secondary count length in fields |
| sg_mask_o | output | 1 | Suppress sense-gate pulses for this field |
| sub_mask_o | output | 1 | Suppress substrate-clear pulses for this field |
| busy_o | output | 1 | Primary exposure in progress |
| aux_tc_o | output | 1 | One-cycle secondary terminal-count pulse |

## Verification
A wrong field index or a wrong latched length shows up as a mask edge one or more fields early or late. That mismatch is visible at the first VD strobe where the edge is due, one cycle after the strobe. A corrupted busy state shows either as a retrigger being accepted, which moves later mask edges, or as busy falling at the wrong VD. The sweep over all small length and skip combinations compares every field, so an off-by-one in any comparison is caught within the first few fields of some configuration. Errors that only appear at the counter width are checked at the 8191-field extreme.

// File: rtl/lexp_pkg.sv
package lexp_pkg;
   localparam int unsigned LEXP_FIELD_W = 13;

   typedef enum logic {
      AUX_IDLE = 1'b0,
      AUX_RUN  = 1'b1
   } aux_state_e;
endpackage

// File: rtl/lexp_seq.sv
module lexp_seq #(
   parameter int unsigned CNT_W   = 13,
   parameter bit          SKIP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vd_i,
   input  logic             arm_en_i,
   input  logic             trig_i,
   input  logic             skip_i,
   input  logic [CNT_W-1:0] sg_len_i,
   input  logic [CNT_W-1:0] sub_len_i,
   output logic             busy_o,
   output logic             adv_o,
   output logic             clr_o,
   output logic [CNT_W:0]   idx_o,
   output logic [CNT_W-1:0] sg_len_o,
   output logic [CNT_W-1:0] sub_len_o
);
   localparam int unsigned IDX_W = CNT_W + 1;

   logic             busy_q;
   logic [IDX_W-1:0] k_q;
   logic [CNT_W-1:0] sgl_q, subl_q;
   logic             skip_q;
   logic             skip_eff;
   logic             start;
   logic [IDX_W-1:0] k_nxt, j_nxt;
   logic [CNT_W-1:0] max_l;

   generate
      if (SKIP_EN) begin : g_skip
         assign skip_eff = skip_i;
      end else begin : g_noskip
         assign skip_eff = 1'b0;
      end
   endgenerate

   assign start = trig_i && arm_en_i && !busy_q;
   assign k_nxt = k_q + {{CNT_W{1'b0}}, 1'b1};
   assign j_nxt = k_nxt - {{CNT_W{1'b0}}, skip_q};
   assign max_l = (sgl_q > subl_q) ? sgl_q : subl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         k_q    <= '0;
         sgl_q  <= '0;
         subl_q <= '0;
         skip_q <= 1'b0;
      end else if (!arm_en_i) begin
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         k_q    <= '0;
         sgl_q  <= sg_len_i;
         subl_q <= sub_len_i;
         skip_q <= skip_eff;
      end else if (busy_q && vd_i) begin
         k_q    <= k_nxt;
         busy_q <= (j_nxt <= {1'b0, max_l});
      end
   end

   assign busy_o    = busy_q;
   assign adv_o     = busy_q && vd_i && arm_en_i;
   assign clr_o     = !arm_en_i;
   assign idx_o     = j_nxt;
   assign sg_len_o  = sgl_q;
   assign sub_len_o = subl_q;
endmodule

// File: rtl/lexp_mask_win.sv
module lexp_mask_win #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic [CNT_W:0]   idx_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             mask_o
);
   logic mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         mask_q <= 1'b0;
      end else if (adv_i) begin
         mask_q <= (idx_i != '0) && (idx_i <= {1'b0, len_i});
      end
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/lexp_aux_cnt.sv
module lexp_aux_cnt
   import lexp_pkg::*;
#(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vd_i,
   input  logic             en_i,
   input  logic             trig_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             tc_o
);
   aux_state_e       st_q;
   logic [CNT_W-1:0] rem_q;
   logic             tc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         st_q  <= AUX_IDLE;
         rem_q <= '0;
         tc_q  <= 1'b0;
      end else begin
         tc_q <= 1'b0;
         case (st_q)
            AUX_IDLE: if (trig_i) begin
               st_q  <= AUX_RUN;
               rem_q <= len_i;
            end
            AUX_RUN: if (vd_i) begin
               if (rem_q <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
                  tc_q <= 1'b1;
                  st_q <= AUX_IDLE;
               end else begin
                  rem_q <= rem_q - {{(CNT_W-1){1'b0}}, 1'b1};
               end
            end
            default: st_q <= AUX_IDLE;
         endcase
      end
   end

   assign tc_o = tc_q;
endmodule

// File: rtl/lexp_mask_ctrl.sv
module lexp_mask_ctrl #(
   parameter int unsigned CNT_W   = lexp_pkg::LEXP_FIELD_W,
   parameter bit          SKIP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vd_i,
   input  logic             arm_en_i,
   input  logic             trig_i,
   input  logic             skip_first_i,
   input  logic [CNT_W-1:0] sg_len_i,
   input  logic [CNT_W-1:0] sub_len_i,
   input  logic             aux_en_i,
   input  logic             aux_trig_i,
   input  logic [CNT_W-1:0] aux_len_i,
   output logic             sg_mask_o,
   output logic             sub_mask_o,
   output logic             busy_o,
   output logic             aux_tc_o
);
   localparam int unsigned N_MASK = 2;

   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("lexp_mask_ctrl: CNT_W must lie in 2..24");
      end
   endgenerate

   logic             adv, clr;
   logic [CNT_W:0]   idx;
   logic [CNT_W-1:0] sgl, subl;
   logic [CNT_W-1:0] len_arr [N_MASK];
   logic [N_MASK-1:0] mask_v;

   lexp_seq #(.CNT_W(CNT_W), .SKIP_EN(SKIP_EN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .vd_i      (vd_i),
      .arm_en_i  (arm_en_i),
      .trig_i    (trig_i),
      .skip_i    (skip_first_i),
      .sg_len_i  (sg_len_i),
      .sub_len_i (sub_len_i),
      .busy_o    (busy_o),
      .adv_o     (adv),
      .clr_o     (clr),
      .idx_o     (idx),
      .sg_len_o  (sgl),
      .sub_len_o (subl)
   );

   assign len_arr[0] = sgl;
   assign len_arr[1] = subl;

   generate
      for (genvar m = 0; m < N_MASK; m++) begin : g_mask
         lexp_mask_win #(.CNT_W(CNT_W)) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .adv_i  (adv),
            .idx_i  (idx),
            .len_i  (len_arr[m]),
            .mask_o (mask_v[m])
         );
      end
   endgenerate

   assign sg_mask_o  = mask_v[0];
   assign sub_mask_o = mask_v[1];

   lexp_aux_cnt #(.CNT_W(CNT_W)) u_aux (
      .clk    (clk),
      .rst_n  (rst_n),
      .vd_i   (vd_i),
      .en_i   (aux_en_i),
      .trig_i (aux_trig_i),
      .len_i  (aux_len_i),
      .tc_o   (aux_tc_o)
   );
endmodule

// File: rtl/lexp_mask_chk.sv
module lexp_mask_chk (
   input logic clk,
   input logic rst_n,
   input logic vd_i,
   input logic arm_en_i,
   input logic trig_i,
   input logic aux_en_i,
   input logic sg_mask_o,
   input logic sub_mask_o,
   input logic busy_o,
   input logic aux_tc_o
);
   // R4 R5
   mask_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sg_mask_o || sub_mask_o) |-> busy_o);

   // R3
   sg_edge_on_vd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(vd_i) && $past(arm_en_i)) |-> $stable(sg_mask_o));

   // R5
   sub_edge_on_vd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(vd_i) && $past(arm_en_i)) |-> $stable(sub_mask_o));

   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(trig_i && arm_en_i));

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(vd_i || !arm_en_i));

   // R10
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_en_i |=> (!busy_o && !sg_mask_o && !sub_mask_o));

   // R11
   aux_tc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aux_tc_o |-> $past(vd_i && aux_en_i));

   // R11
   aux_tc_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aux_tc_o |=> !aux_tc_o);
endmodule

bind lexp_mask_ctrl lexp_mask_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vd_i       (vd_i),
   .arm_en_i   (arm_en_i),
   .trig_i     (trig_i),
   .aux_en_i   (aux_en_i),
   .sg_mask_o  (sg_mask_o),
   .sub_mask_o (sub_mask_o),
   .busy_o     (busy_o),
   .aux_tc_o   (aux_tc_o)
);

// File: tb/tb_lexp_mask_ctrl.sv
module tb_lexp_mask_ctrl;
   localparam int W = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vd_i = 1'b0, arm_en_i = 1'b0, trig_i = 1'b0, skip_first_i = 1'b0;
   logic [W-1:0] sg_len_i = '0, sub_len_i = '0, aux_len_i = '0;
   logic aux_en_i = 1'b0, aux_trig_i = 1'b0;
   logic sg_mask_o, sub_mask_o, busy_o, aux_tc_o;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   lexp_mask_ctrl #(.CNT_W(W)) dut (.*);

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic vd_pulse();
      @(negedge clk) vd_i = 1'b1;
      @(negedge clk) vd_i = 1'b0;
   endtask

   task automatic prim_trig();
      @(negedge clk) trig_i = 1'b1;
      @(negedge clk) trig_i = 1'b0;
   endtask

   task automatic aux_pulse();
      @(negedge clk) aux_trig_i = 1'b1;
      @(negedge clk) aux_trig_i = 1'b0;
   endtask

   function automatic int in_win(input int j, input int len);
      return (j >= 1 && j <= len) ? 1 : 0;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 sg", sg_mask_o, 0);
      check("R1 busy", busy_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 sub", sub_mask_o, 0);
      check("R1 tc", aux_tc_o, 0);
      arm_en_i = 1'b1;

      // R4 R5 R6 R7 R8 sweep
      for (int sg = 0; sg < 4; sg++)
         for (int sb = 0; sb < 4; sb++)
            for (int sk = 0; sk < 2; sk++) begin
               int mx;
               sg_len_i = W'(sg);
               sub_len_i = W'(sb);
               skip_first_i = sk[0];
               mx = (sg > sb) ? sg : sb;
               prim_trig();
               check("R2 busy after trig", busy_o, 1);
               check("R3 sg before vd", sg_mask_o, 0);
               for (int k = 1; k <= mx + sk + 2; k++) begin
                  int j;
                  j = k - sk;
                  vd_pulse();
                  check("R4 sg", sg_mask_o, in_win(j, sg));
                  check("R5 sub", sub_mask_o, in_win(j, sb));
                  check("R8 busy", busy_o, (j <= mx) ? 1 : 0);
               end
            end

      // R2 trigger while disabled
      arm_en_i = 1'b0;
      sg_len_i = 2;
      skip_first_i = 1'b0;
      prim_trig();
      check("R2 disabled trig busy", busy_o, 0);
      arm_en_i = 1'b1;
      vd_pulse();
      check("R2 disabled trig sg", sg_mask_o, 0);

      // R2 retrigger while busy
      sg_len_i = 3;
      sub_len_i = 2;
      prim_trig();
      vd_pulse();
      sg_len_i = 1;
      skip_first_i = 1'b1;
      prim_trig();
      check("R2 retrig busy", busy_o, 1);
      vd_pulse();
      check("R2 retrig f2 sg", sg_mask_o, 1);
      check("R2 retrig f2 sub", sub_mask_o, 1);
      vd_pulse();
      check("R2 retrig f3 sg", sg_mask_o, 1);
      check("R2 retrig f3 sub", sub_mask_o, 0);
      vd_pulse();
      check("R2 retrig f4 sg", sg_mask_o, 0);
      check("R2 retrig f4 busy", busy_o, 0);

      // R10 abort
      skip_first_i = 1'b0;
      sg_len_i = 3;
      sub_len_i = 3;
      prim_trig();
      vd_pulse();
      check("R10 pre-abort sg", sg_mask_o, 1);
      @(negedge clk) arm_en_i = 1'b0;
      @(negedge clk);
      check("R10 abort busy", busy_o, 0);
      check("R10 abort sg", sg_mask_o, 0);
      check("R10 abort sub", sub_mask_o, 0);
      arm_en_i = 1'b1;
      vd_pulse();
      check("R10 after abort sg", sg_mask_o, 0);

      // R11 R12 secondary counter
      aux_en_i = 1'b1;
      aux_len_i = 3;
      aux_pulse();
      for (int k = 1; k <= 4; k++) begin
         vd_pulse();
         check("R11 tc len3", aux_tc_o, (k == 3) ? 1 : 0);
         check("R12 busy idle", busy_o, 0);
         check("R12 sg idle", sg_mask_o, 0);
         @(negedge clk);
         check("R11 tc width", aux_tc_o, 0);
      end
      aux_len_i = 0;
      aux_pulse();
      vd_pulse();
      check("R11 tc len0", aux_tc_o, 1);
      aux_len_i = 3;
      aux_pulse();
      vd_pulse();
      aux_len_i = 1;
      aux_pulse();
      vd_pulse();
      check("R11 ignored retrig", aux_tc_o, 0);
      vd_pulse();
      check("R11 tc after retrig", aux_tc_o, 1);
      aux_len_i = 2;
      aux_pulse();
      vd_pulse();
      @(negedge clk) aux_en_i = 1'b0;
      @(negedge clk) aux_en_i = 1'b1;
      vd_pulse();
      check("R11 disabled stop", aux_tc_o, 0);

      // R12 primary with secondary running
      sg_len_i = 2;
      sub_len_i = 1;
      prim_trig();
      aux_len_i = 1;
      aux_pulse();
      vd_pulse();
      check("R12 tc", aux_tc_o, 1);
      check("R12 sg f1", sg_mask_o, 1);
      check("R12 sub f1", sub_mask_o, 1);
      vd_pulse();
      check("R12 sg f2", sg_mask_o, 1);
      check("R12 sub f2", sub_mask_o, 0);
      vd_pulse();
      check("R12 busy end", busy_o, 0);
      aux_en_i = 1'b0;

      // R9 maximum length
      sg_len_i = 8191;
      sub_len_i = 5;
      skip_first_i = 1'b1;
      prim_trig();
      for (int k = 1; k <= 8193; k++) begin
         vd_pulse();
         if (k == 1) check("R9 skip field sg", sg_mask_o, 0);
         if (k == 2) check("R9 first sg", sg_mask_o, 1);
         if (k == 7) check("R9 sub end", sub_mask_o, 0);
         if (k == 8192) begin
            check("R9 last sg", sg_mask_o, 1);
            check("R9 last busy", busy_o, 1);
         end
         if (k == 8193) begin
            check("R9 sg end", sg_mask_o, 0);
            check("R9 busy end", busy_o, 0);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule